// File: doc/BRIEF.md
# Backplane Bus Requester and Arbiter

This unit lets a module take part in a shared backplane with four request levels. The requester side raises the module's configured level when the local side needs the bus. It waits for a grant from the arbiter and then drives busy for as long as it owns the bus. It gives the bus up under one of two policies. Under the hold policy the bus stays owned until another module raises a request. Under the done policy the bus is dropped as soon as the local cycle ends. An optional fairness delay can follow a release. During that delay the requester withholds a new request while other requests are pending, or until a timeout that is counted in 2 µs steps runs out.

When the module is the system controller, the same unit also arbitrates all four levels. It can use fixed priority or a rotating order. It is also the only unit allowed to pulse the bus reset at initialization, and only when that is enabled. A free-running microsecond prescaler, set from the clock frequency, times the fairness delay.

Top module: `bus_arb_unit`

## Requirements
- R1: After reset, `bus_req_out`, `bus_busy_out`, `bus_grant_out` and `bus_reset_out` are all zero.
- R2: When the requester is idle and `local_need` is high with fairness off, `bus_req_out` shows exactly one bit one cycle later. That bit is bit `cfg_level`, where bit i is level i.
- R3: While requesting, a grant with `bus_busy_in` low makes `bus_busy_out` rise one cycle later, and the request drops in that same cycle. Busy never rises without a request in the previous cycle.
- R4: With `cfg_release_mode`=1 (release when done), `bus_busy_out` falls one cycle after `cycle_done` while owning.
- R5: With `cfg_release_mode`=0 (release on request), `bus_busy_out` stays high after `cycle_done` while `bus_req_in` is zero. It falls one cycle after any bit of `bus_req_in` rises.
- R6: With `cfg_prio_mode`=1, the arbiter grants the highest-numbered requesting level (level 3 highest). The grant appears one cycle after the request is seen with the bus not busy.
- R7: With `cfg_prio_mode`=0, the search starts at the level after the last granted one. Every grant in either mode updates the last-granted record, and after reset the first search starts at level 0.
- R8: `bus_grant_out` is at most one-hot and is zero unless `cfg_sysctl`=1. A grant falls one cycle after busy (`bus_busy_in` or `bus_busy_out`) is seen. No grant is issued while busy.
- R9: With `cfg_fair_code`=0 a released requester may request again one cycle after release. With a nonzero code it withholds its request while any `bus_req_in` bit is high, and may request again two cycles after `bus_req_in` becomes zero.
- R10: With `cfg_fair_code`=c in 1..14 the withholding ends after c×2 µs (within a few cycles) even if requests stay high. With code 15 it never times out.
- R11: `init_pulse` with `cfg_sysctl`=1 and `cfg_reset_en`=1 drives `bus_reset_out` high for exactly RST_CYCLES cycles, starting one cycle later. Otherwise `bus_reset_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 2 | Own request level (0..3) |
| cfg_prio_mode | input | 1 | 1 = fixed priority, 0 = rotating arbitration |
| cfg_release_mode | input | 1 | 1 = release when done, 0 = release on request |
| cfg_fair_code | input | 4 | 0 off, 1..14 timeout code×2 µs, 15 no timeout |
| cfg_sysctl | input | 1 | Module is the system controller |
| cfg_reset_en | input | 1 | Allow the bus reset pulse at initialization |
| init_pulse | input | 1 | Initialization strobe |
| local_need | input | 1 | Local side wants the bus |
| cycle_done | input | 1 | Local cycle finished |
| grant_in | input | 1 | Grant from an external arbiter (used when not system controller) |
| bus_req_in | input | 4 | Request lines of other modules, bit i = level i |
| bus_busy_in | input | 1 | Busy line driven by other modules |
| bus_req_out | output | 4 | Own request, one-hot at own level |
| bus_busy_out | output | 1 | Own busy (bus owned) |
| bus_grant_out | output | 4 | Arbiter grant per level |
| bus_reset_out | output | 1 | Bus reset drive |

## Verification
Every result comes from a register, so request, busy, grant and reset each react one clock after the stimulus that causes them. The only exception is that a fairness release with clear lines takes two clocks: one to leave the wait state and one to request. Inputs change on the falling edge and outputs are read on the next falling edge, so each check reads exactly one register stage later. The fairness timeout is measured against windows a few cycles before and after c×2×CLK_PER_US cycles. That covers the prescaler phase and the exit stages.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int LEVELS = 4;
    localparam int LVL_W  = $clog2(LEVELS);

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [LEVELS-1:0] lvec_t;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_WAIT,
        RQ_OWN,
        RQ_HOLD,
        RQ_FAIR
    } rq_state_e;

    typedef enum logic [1:0] {
        AR_IDLE,
        AR_GRANT,
        AR_BUSY
    } ar_state_e;
endpackage

// File: rtl/arb_tick.sv
module arb_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_US - 1);

    typedef struct packed {
        logic [CNT_W-1:0] pre;
    } tick_s;

    tick_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        tick = (t_q.pre == LAST);
        if (restart || tick) begin
            t_d.pre = '0;
        end else begin
            t_d.pre = t_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/arb_core.sv
module arb_core
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  prio_mode,
    input  lvec_t req,
    input  logic  busy,
    output lvec_t grant
);
    typedef struct packed {
        ar_state_e st;
        level_t    last;
        level_t    win;
        lvec_t     gnt;
    } core_s;

    core_s c_d, c_q;
    level_t pick;

    always_comb begin
        pick = '0;
        if (prio_mode) begin
            for (int i = 0; i < LEVELS; i++) begin
                if (req[i]) pick = level_t'(i);
            end
        end else begin
            for (int k = LEVELS; k >= 1; k--) begin
                if (req[c_q.last + level_t'(k)]) pick = c_q.last + level_t'(k);
            end
        end
    end

    always_comb begin
        c_d = c_q;
        if (!enable) begin
            c_d.st  = AR_IDLE;
            c_d.gnt = '0;
        end else begin
            unique case (c_q.st)
                AR_IDLE: begin
                    if (|req && !busy) begin
                        c_d.st        = AR_GRANT;
                        c_d.win       = pick;
                        c_d.last      = pick;
                        c_d.gnt       = '0;
                        c_d.gnt[pick] = 1'b1;
                    end
                end
                AR_GRANT: begin
                    if (busy) begin
                        c_d.st  = AR_BUSY;
                        c_d.gnt = '0;
                    end else if (!req[c_q.win]) begin
                        c_d.st  = AR_IDLE;
                        c_d.gnt = '0;
                    end
                end
                AR_BUSY: begin
                    if (!busy) c_d.st = AR_IDLE;
                end
                default: begin
                    c_d.st  = AR_IDLE;
                    c_d.gnt = '0;
                end
            endcase
        end
    end

    assign grant = c_q.gnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= AR_IDLE;
            c_q.last <= level_t'(LEVELS - 1);
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/arb_requester.sv
module arb_requester
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  level_t     level,
    input  logic       release_mode,
    input  logic [3:0] fair_code,
    input  logic       local_need,
    input  logic       cycle_done,
    input  logic       grant,
    input  lvec_t      other_req,
    input  logic       busy_in,
    input  logic       tick,
    output lvec_t      req_out,
    output logic       busy_out,
    output logic       tick_restart
);
    typedef struct packed {
        rq_state_e  st;
        logic [4:0] us_cnt;
    } rq_s;

    rq_s r_d, r_q;
    logic fair_on, fair_expired;
    rq_state_e after_release;

    always_comb begin
        r_d           = r_q;
        req_out       = '0;
        busy_out      = 1'b0;
        fair_on       = (fair_code != 4'd0);
        fair_expired  = (fair_code != 4'hF) && (r_q.us_cnt >= {fair_code, 1'b0});
        after_release = fair_on ? RQ_FAIR : RQ_IDLE;

        unique case (r_q.st)
            RQ_IDLE: begin
                if (local_need) r_d.st = RQ_WAIT;
            end
            RQ_WAIT: begin
                req_out[level] = 1'b1;
                if (grant && !busy_in) r_d.st = RQ_OWN;
            end
            RQ_OWN: begin
                busy_out = 1'b1;
                if (cycle_done) begin
                    if (release_mode) begin
                        r_d.st     = after_release;
                        r_d.us_cnt = '0;
                    end else begin
                        r_d.st = RQ_HOLD;
                    end
                end
            end
            RQ_HOLD: begin
                busy_out = 1'b1;
                if (release_mode || (|other_req)) begin
                    r_d.st     = after_release;
                    r_d.us_cnt = '0;
                end else if (local_need) begin
                    r_d.st = RQ_OWN;
                end
            end
            RQ_FAIR: begin
                if (tick && r_q.us_cnt != 5'h1F) r_d.us_cnt = r_q.us_cnt + 5'd1;
                if (!(|other_req) || fair_expired) r_d.st = RQ_IDLE;
            end
            default: r_d.st = RQ_IDLE;
        endcase

        tick_restart = (r_d.st == RQ_FAIR) && (r_q.st != RQ_FAIR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= RQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/bus_arb_unit.sv
module bus_arb_unit
    import arb_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_level,
    input  logic       cfg_prio_mode,
    input  logic       cfg_release_mode,
    input  logic [3:0] cfg_fair_code,
    input  logic       cfg_sysctl,
    input  logic       cfg_reset_en,
    input  logic       init_pulse,
    input  logic       local_need,
    input  logic       cycle_done,
    input  logic       grant_in,
    input  logic [3:0] bus_req_in,
    input  logic       bus_busy_in,
    output logic [3:0] bus_req_out,
    output logic       bus_busy_out,
    output logic [3:0] bus_grant_out,
    output logic       bus_reset_out
);
    localparam int RST_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [RST_W-1:0] cnt;
    } rst_s;

    rst_s  s_d, s_q;
    logic  tick, tick_restart, own_grant;
    lvec_t all_req;
    logic  all_busy;

    assign all_req   = bus_req_in | bus_req_out;
    assign all_busy  = bus_busy_in | bus_busy_out;
    assign own_grant = cfg_sysctl ? bus_grant_out[cfg_level] : grant_in;

    arb_tick #(.CLK_PER_US(CLK_PER_US)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tick_restart),
        .tick    (tick)
    );

    arb_core i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_sysctl),
        .prio_mode (cfg_prio_mode),
        .req       (all_req),
        .busy      (all_busy),
        .grant     (bus_grant_out)
    );

    arb_requester i_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .level        (cfg_level),
        .release_mode (cfg_release_mode),
        .fair_code    (cfg_fair_code),
        .local_need   (local_need),
        .cycle_done   (cycle_done),
        .grant        (own_grant),
        .other_req    (bus_req_in),
        .busy_in      (bus_busy_in),
        .tick         (tick),
        .req_out      (bus_req_out),
        .busy_out     (bus_busy_out),
        .tick_restart (tick_restart)
    );

    always_comb begin
        s_d = s_q;
        if (init_pulse && cfg_sysctl && cfg_reset_en) begin
            s_d.cnt = RST_W'(RST_CYCLES);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    assign bus_reset_out = (s_q.cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/arb_unit_checks.sv
module arb_unit_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_release_mode,
    input logic       cfg_sysctl,
    input logic       cycle_done,
    input logic [3:0] bus_req_in,
    input logic       bus_busy_in,
    input logic [3:0] bus_req_out,
    input logic       bus_busy_out,
    input logic [3:0] bus_grant_out,
    input logic       bus_reset_out
);
    p_req_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_req_out));

    p_req_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !((|bus_req_out) && bus_busy_out));

    p_busy_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy_out) |-> $past(|bus_req_out));

    p_rwd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy_out && cycle_done && cfg_release_mode) |=> !bus_busy_out);

    p_ror_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy_out && !cfg_release_mode && bus_req_in == 4'd0) |=> bus_busy_out);

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant_out));

    p_grant_ctrl_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sysctl && $past(!cfg_sysctl)) |-> (bus_grant_out == 4'd0));

    p_no_grant_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|bus_grant_out) |-> !$past(bus_busy_in || bus_busy_out));

    p_reset_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_out |-> cfg_sysctl);
endmodule

bind bus_arb_unit arb_unit_checks i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_release_mode (cfg_release_mode),
    .cfg_sysctl       (cfg_sysctl),
    .cycle_done       (cycle_done),
    .bus_req_in       (bus_req_in),
    .bus_busy_in      (bus_busy_in),
    .bus_req_out      (bus_req_out),
    .bus_busy_out     (bus_busy_out),
    .bus_grant_out    (bus_grant_out),
    .bus_reset_out    (bus_reset_out)
);

// File: tb/test_bus_arb_unit.sv
`timescale 1ns/1ps
module test_bus_arb_unit;
    localparam int CPU = 50;
    localparam int RSTC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_level = 2'd0;
    logic cfg_prio_mode = 1'b0, cfg_release_mode = 1'b1;
    logic [3:0] cfg_fair_code = 4'd0;
    logic cfg_sysctl = 1'b1, cfg_reset_en = 1'b1;
    logic init_pulse = 1'b0, local_need = 1'b0, cycle_done = 1'b0, grant_in = 1'b0;
    logic [3:0] bus_req_in = 4'd0;
    logic bus_busy_in = 1'b0;
    logic [3:0] bus_req_out, bus_grant_out;
    logic bus_busy_out, bus_reset_out;

    int total = 0;
    int bad = 0;
    int last_m = 3;

    always #10 clk = ~clk;

    bus_arb_unit #(.CLK_PER_US(CPU), .RST_CYCLES(RSTC)) i_bus_arb_unit (
        .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_prio_mode(cfg_prio_mode),
        .cfg_release_mode(cfg_release_mode), .cfg_fair_code(cfg_fair_code),
        .cfg_sysctl(cfg_sysctl), .cfg_reset_en(cfg_reset_en), .init_pulse(init_pulse),
        .local_need(local_need), .cycle_done(cycle_done), .grant_in(grant_in),
        .bus_req_in(bus_req_in), .bus_busy_in(bus_busy_in), .bus_req_out(bus_req_out),
        .bus_busy_out(bus_busy_out), .bus_grant_out(bus_grant_out), .bus_reset_out(bus_reset_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_winner(input logic [3:0] r, input bit prio, input int last);
        int w = -1;
        if (prio) begin
            for (int i = 3; i >= 0; i--) if (w < 0 && r[i]) w = i;
        end else begin
            for (int k = 1; k <= 4; k++) if (w < 0 && r[(last + k) % 4]) w = (last + k) % 4;
        end
        return w;
    endfunction

    // Own a bus cycle as a non-controller using grant_in
    task automatic acquire(input logic [1:0] lvl);
        cfg_level = lvl;
        local_need = 1'b1;
        cyc(1);
        check(bus_req_out == (4'd1 << lvl), "R2 request bit", bus_req_out, 1 << lvl);
        grant_in = 1'b1;
        cyc(1);
        check(bus_busy_out == 1'b1, "R3 busy after grant", bus_busy_out, 1);
        check(bus_req_out == 4'd0, "R3 request dropped", bus_req_out, 0);
        grant_in = 1'b0;
        local_need = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [3:0] r;
        int w;
        void'($urandom(32'd4242));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check(bus_req_out == 0 && bus_busy_out == 0 && bus_grant_out == 0 && bus_reset_out == 0,
              "R1 reset state", {bus_req_out, bus_busy_out, bus_grant_out, bus_reset_out}, 0);

        // R6 / R7 / R8: random arbitration trials, own requester idle
        for (int t = 0; t < 60; t++) begin
            r = 4'($urandom_range(1, 15));
            cfg_prio_mode = (t < 4) ? 1'b0 : 1'($urandom_range(0, 1));
            bus_req_in = r;
            w = exp_winner(r, cfg_prio_mode, last_m);
            last_m = w;
            cyc(1);
            check(bus_grant_out == (4'd1 << w), cfg_prio_mode ? "R6 priority grant" : "R7 rotating grant",
                  bus_grant_out, 1 << w);
            bus_busy_in = 1'b1;
            bus_req_in = 4'd0;
            cyc(1);
            check(bus_grant_out == 4'd0, "R8 grant drops on busy", bus_grant_out, 0);
            bus_req_in = 4'($urandom_range(1, 15));
            cyc(2);
            check(bus_grant_out == 4'd0, "R8 no grant while busy", bus_grant_out, 0);
            bus_busy_in = 1'b0;
            bus_req_in = 4'd0;
            cyc(2);
        end

        // R8: no grant when not controller
        cfg_sysctl = 1'b0;
        cyc(1);
        bus_req_in = 4'b0110;
        cyc(2);
        check(bus_grant_out == 4'd0, "R8 grant needs controller", bus_grant_out, 0);
        bus_req_in = 4'd0;
        cyc(1);

        // R2 R3 R4: release when done
        cfg_release_mode = 1'b1;
        acquire(2'd2);
        cyc(2);
        check(bus_busy_out == 1'b1, "R4 busy held until done", bus_busy_out, 1);
        cycle_done = 1'b1;
        cyc(1);
        cycle_done = 1'b0;
        check(bus_busy_out == 1'b0, "R4 release when done", bus_busy_out, 0);
        cyc(1);

        // R5: release on request
        cfg_release_mode = 1'b0;
        acquire(2'd1);
        cycle_done = 1'b1;
        cyc(1);
        cycle_done = 1'b0;
        cyc(3);
        check(bus_busy_out == 1'b1, "R5 held after done", bus_busy_out, 1);
        bus_req_in = 4'b0001;
        cyc(1);
        check(bus_busy_out == 1'b0, "R5 released on request", bus_busy_out, 0);
        bus_req_in = 4'd0;
        cyc(2);

        // R9: fairness off, immediate re-request
        cfg_release_mode = 1'b1;
        cfg_fair_code = 4'd0;
        acquire(2'd0);
        bus_req_in = 4'b0100;
        local_need = 1'b1;
        cycle_done = 1'b1;
        cyc(1);
        cycle_done = 1'b0;
        cyc(1);
        check(bus_req_out == 4'b0001, "R9 no fairness re-request", bus_req_out, 1);
        local_need = 1'b0;
        grant_in = 1'b1;
        cyc(1);
        grant_in = 1'b0;
        cycle_done = 1'b1;
        cyc(1);
        cycle_done = 1'b0;
        bus_req_in = 4'd0;
        cyc(1);

        // R9 / R10: fairness without timeout
        cfg_fair_code = 4'hF;
        acquire(2'd3);
        bus_req_in = 4'b0010;
        local_need = 1'b1;
        cycle_done = 1'b1;
        cyc(1);
        cycle_done = 1'b0;
        cyc(20);
        check(bus_req_out == 4'd0, "R9 withheld while others request", bus_req_out, 0);
        cyc(3000);
        check(bus_req_out == 4'd0, "R10 code 15 never times out", bus_req_out, 0);
        bus_req_in = 4'd0;
        cyc(2);
        check(bus_req_out == 4'b1000, "R9 request after lines clear", bus_req_out, 8);
        local_need = 1'b0;
        grant_in = 1'b1;
        cyc(1);
        grant_in = 1'b0;
        cycle_done = 1'b1;
        cyc(1);
        cycle_done = 1'b0;
        cyc(2);

        // R10: timeouts for codes 1 and 3
        for (int c = 1; c <= 3; c += 2) begin
            cfg_fair_code = 4'(c);
            acquire(2'd1);
            bus_req_in = 4'b1000;
            local_need = 1'b1;
            cycle_done = 1'b1;
            cyc(1);
            cycle_done = 1'b0;
            cyc(2 * c * CPU - 5);
            check(bus_req_out == 4'd0, "R10 before timeout", bus_req_out, 0);
            cyc(10);
            check(bus_req_out == 4'b0010, "R10 after timeout", bus_req_out, 2);
            local_need = 1'b0;
            grant_in = 1'b1;
            cyc(1);
            grant_in = 1'b0;
            bus_req_in = 4'd0;
            cycle_done = 1'b1;
            cyc(1);
            cycle_done = 1'b0;
            cyc(2);
        end
        cfg_fair_code = 4'd0;

        // R6: own level as controller, priority over level 0
        cfg_sysctl = 1'b1;
        cfg_prio_mode = 1'b1;
        cfg_level = 2'd3;
        cyc(1);
        local_need = 1'b1;
        cyc(1);
        bus_req_in = 4'b0001;
        cyc(1);
        check(bus_grant_out == 4'b1000, "R6 own top level wins", bus_grant_out, 8);
        local_need = 1'b0;
        bus_req_in = 4'd0;
        cyc(1);
        check(bus_busy_out == 1'b1, "R3 own grant gives busy", bus_busy_out, 1);
        cycle_done = 1'b1;
        cyc(1);
        cycle_done = 1'b0;
        cyc(2);

        // R11: bus reset pulse
        init_pulse = 1'b1;
        cyc(1);
        init_pulse = 1'b0;
        check(bus_reset_out == 1'b1, "R11 reset starts", bus_reset_out, 1);
        cyc(RSTC - 1);
        check(bus_reset_out == 1'b1, "R11 reset last cycle", bus_reset_out, 1);
        cyc(1);
        check(bus_reset_out == 1'b0, "R11 reset ends", bus_reset_out, 0);
        cfg_reset_en = 1'b0;
        init_pulse = 1'b1;
        cyc(1);
        init_pulse = 1'b0;
        cyc(2);
        check(bus_reset_out == 1'b0, "R11 reset disabled", bus_reset_out, 0);
        cfg_reset_en = 1'b1;
        cfg_sysctl = 1'b0;
        cyc(1);
        init_pulse = 1'b1;
        cyc(1);
        init_pulse = 1'b0;
        cyc(2);
        check(bus_reset_out == 1'b0, "R11 reset needs controller", bus_reset_out, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule